// File: doc/BRIEF.md
# Accumulator Processor with Unified Code and Data Memory

This block is a small 8-bit processor built around a single accumulator. It owns a 32-byte memory that holds both the program and its working data. Each instruction goes through three steps: it is fetched from memory, decoded, and then executed. Instructions can load, store and subtract memory operands. They can read a byte from an external input port, branch on zero or on a positive accumulator, and halt. The accumulator is visible on an output port, and a flag reports that the program has stopped.

The memory image loaded at reset is a parameter. The default image reads two bytes from the input port and leaves their distance in the accumulator. An integrator can pass a different image to run a different fixed program. A new program is started by pulsing reset.

Top module: `acc_cpu`

## Requirements
- R1: Every instruction is a single byte fetched at the 5-bit program counter. Bits 7:5 are the opcode and bits 4:0 are a direct address or a branch target. After executing the instruction at location 31, the program counter advances to 0.
- R2: Opcode 000 copies the memory byte at the address field into the accumulator. Opcode 001 writes the accumulator into memory at the address field, and later loads of that location return the written value.
- R3: Opcode 011 sets the accumulator to the accumulator minus the memory byte at the address field, modulo 256.
- R4: Opcode 100 waits in its execute step while in_valid_i is low. During the wait the accumulator and the program counter are unchanged. In the first cycle that in_valid_i is high, the instruction loads in_data_i into the accumulator.
- R5: Opcode 101 branches to the address field when the accumulator is zero. Otherwise execution continues at the next location.
- R6: Opcode 110 branches to the address field when the accumulator is positive, meaning nonzero with bit 7 clear. Otherwise execution continues at the next location.
- R7: Opcode 010 changes neither the accumulator nor memory, and execution continues at the next location.
- R8: Opcode 111 (byte 0xFF) stops the processor and raises halted_o. From then until reset, halted_o stays high, acc_o keeps its value and the input port has no effect.
- R9: While rst_ni is low, acc_o is 0 and halted_o is 0. After reset, execution starts at location 0 with the parameter memory image loaded again, so data written by an earlier run is gone.
- R10: The default image reads a first byte a and then a second byte b from the input port, and halts with result d = a - b (mod 256). If d is zero or positive, the accumulator holds d; otherwise it holds b - a (mod 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | 8 | Byte for the input instruction |
| in_valid_i | input | 1 | High when in_data_i may be taken |
| acc_o | output | 8 | Accumulator value |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
The bench runs the default program on equal operands and on operands in both orders. One pair's difference has bit 7 set, so a design that tests only for a nonzero value as "positive" leaves the wrong result. A second instance runs a test image that reaches location 31 and must wrap to location 0. That image also runs a no-op, stores into a data cell and reads it back, and branches on values on both sides of the sign boundary. A design that saturates the program counter or decodes 010 as a load computes a wrong value or never halts. The bench also holds the input strobe low for many cycles, toggles the input after a halt, and runs the same operand twice across reset. A design that captures a stale input, keeps running after the halt, or does not restore the data cell on reset fails these checks.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'b000,
    OP_STORE = 3'b001,
    OP_NOP   = 3'b010,
    OP_SUB   = 3'b011,
    OP_IN    = 3'b100,
    OP_JZ    = 3'b101,
    OP_JP    = 3'b110,
    OP_HALT  = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_MEM  = 2'd1,
    ACC_SUB  = 2'd2,
    ACC_IN   = 2'd3
  } acc_op_e;

  // default program: distance between two input bytes
  function automatic logic [255:0] default_image();
    logic [255:0] img;
    img = '0;
    img[8*0  +: 8] = 8'h80; // in
    img[8*1  +: 8] = 8'h3E; // store 30
    img[8*2  +: 8] = 8'h80; // in
    img[8*3  +: 8] = 8'h3F; // store 31
    img[8*4  +: 8] = 8'h1E; // load 30
    img[8*5  +: 8] = 8'h7F; // sub 31
    img[8*6  +: 8] = 8'hAA; // jz 10
    img[8*7  +: 8] = 8'hCA; // jp 10
    img[8*8  +: 8] = 8'h1F; // load 31
    img[8*9  +: 8] = 8'h7E; // sub 30
    img[8*10 +: 8] = 8'hFF; // halt
    return img;
  endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W*(1<<ADDR_W)-1:0] INIT_IMAGE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_IMAGE[i*DATA_W +: DATA_W];
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // registered read, old data on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_op_e           op_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              pos_o
);
  logic [DATA_W-1:0] acc_q, acc_d;

  always_comb begin
    unique case (op_i)
      ACC_MEM: acc_d = mem_data_i;
      ACC_SUB: acc_d = acc_q - mem_data_i;
      ACC_IN:  acc_d = in_data_i;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o  = acc_q;
  assign zero_o = (acc_q == '0);
  assign pos_o  = !acc_q[DATA_W-1] && (acc_q != '0);
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] instr_i,
  input  logic              in_valid_i,
  input  logic              acc_zero_i,
  input  logic              acc_pos_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output acc_op_e           acc_op_o,
  output logic              halted_o,
  output state_e            state_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  op_e               op, new_op;
  logic [ADDR_W-1:0] field;
  logic              take_branch;

  assign op     = op_e'(ir_q[DATA_W-1:ADDR_W]);
  assign new_op = op_e'(instr_i[DATA_W-1:ADDR_W]);
  assign field  = ir_q[ADDR_W-1:0];

  assign take_branch = (op == OP_JZ && acc_zero_i) || (op == OP_JP && acc_pos_i);

  always_comb begin
    rd_addr_o = pc_q;
    if (state_q == ST_DECODE) rd_addr_o = instr_i[ADDR_W-1:0];
  end

  assign wr_en_o   = (state_q == ST_EXEC) && (op == OP_STORE);
  assign wr_addr_o = field;

  always_comb begin
    acc_op_o = ACC_HOLD;
    if (state_q == ST_EXEC) begin
      unique case (op)
        OP_LOAD: acc_op_o = ACC_MEM;
        OP_SUB:  acc_op_o = ACC_SUB;
        OP_IN:   acc_op_o = in_valid_i ? ACC_IN : ACC_HOLD;
        default: acc_op_o = ACC_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: state_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q <= instr_i;
          if (new_op == OP_HALT) begin
            state_q <= ST_HALT;
          end else begin
            pc_q    <= pc_q + ADDR_W'(1);
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (!(op == OP_IN && !in_valid_i)) begin
            if (take_branch) pc_q <= field;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign halted_o = (state_q == ST_HALT);
  assign state_o  = state_q;
  assign ir_o     = ir_q;
  assign pc_o     = pc_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W*(1<<ADDR_W)-1:0] INIT_IMAGE = acc_cpu_pkg::default_image()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              halted_o
);
  logic [ADDR_W-1:0] rd_addr, wr_addr, pc;
  logic [DATA_W-1:0] rdata, ir;
  logic              wr_en, acc_zero, acc_pos;
  acc_op_e           acc_op;
  state_e            state;

  acc_cpu_mem #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_IMAGE(INIT_IMAGE)
  ) u_mem (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rdata),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(acc_o)
  );

  acc_cpu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .instr_i(rdata), .in_valid_i,
    .acc_zero_i(acc_zero), .acc_pos_i(acc_pos),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .acc_op_o(acc_op), .halted_o,
    .state_o(state), .ir_o(ir), .pc_o(pc)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i, .rst_ni,
    .op_i(acc_op), .mem_data_i(rdata), .in_data_i,
    .acc_o, .zero_o(acc_zero), .pos_o(acc_pos)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] acc_o,
  input logic              halted_o,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input state_e            state_i,
  input logic [DATA_W-1:0] ir_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] rdata_i
);
  op_e  op;
  logic ex;
  assign op = op_e'(ir_i[DATA_W-1:ADDR_W]);
  assign ex = (state_i == ST_EXEC);

  a_r8_halt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(acc_o) && $stable(pc_i));

  a_r4_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_IN && !in_valid_i) |=> (state_i == ST_EXEC) && $stable(acc_o) && $stable(pc_i));

  a_r4_in_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_IN && in_valid_i) |=> acc_o == $past(in_data_i));

  a_r3_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_SUB) |=> acc_o == DATA_W'($past(acc_o) - $past(rdata_i)));

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_LOAD) |=> acc_o == $past(rdata_i));

  a_r5_jz_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_JZ && acc_o == '0) |=> pc_i == $past(ir_i[ADDR_W-1:0]));

  a_r6_jp_fallthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_JP && (acc_o == '0 || acc_o[DATA_W-1])) |=> $stable(pc_i));

  a_r7_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex && op == OP_NOP) |=> $stable(acc_o) && $stable(pc_i));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .acc_o, .halted_o, .in_valid_i, .in_data_i,
  .state_i(state), .ir_i(ir), .pc_i(pc), .rdata_i(rdata)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
  function automatic logic [255:0] test_image();
    logic [255:0] img;
    img = '0;
    img[8*0  +: 8] = 8'hA3; // jz 3
    img[8*1  +: 8] = 8'hFF; // halt
    img[8*3  +: 8] = 8'h80; // in
    img[8*4  +: 8] = 8'h40; // nop
    img[8*5  +: 8] = 8'h7C; // sub 28
    img[8*6  +: 8] = 8'h3C; // store 28
    img[8*7  +: 8] = 8'h1C; // load 28
    img[8*8  +: 8] = 8'hDF; // jp 31
    img[8*9  +: 8] = 8'h7C; // sub 28
    img[8*10 +: 8] = 8'hFF; // halt
    img[8*28 +: 8] = 8'h01;
    img[8*31 +: 8] = 8'h40; // nop, then wrap
    return img;
  endfunction
  localparam logic [255:0] TEST_IMG = test_image();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data0 = '0, in_data1 = '0;
  logic in_valid0 = 1'b0, in_valid1 = 1'b0;
  logic [7:0] acc0, acc1;
  logic halted0, halted1;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  acc_cpu u0 (.clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data0), .in_valid_i(in_valid0),
              .acc_o(acc0), .halted_o(halted0));
  acc_cpu #(.INIT_IMAGE(TEST_IMG)) u1 (.clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data1),
              .in_valid_i(in_valid1), .acc_o(acc1), .halted_o(halted1));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_halt(int which);
    for (int i = 0; i < 1000; i++) begin
      if ((which == 0 && halted0) || (which == 1 && halted1)) return;
      @(negedge clk);
    end
    chk("R8 halt never reached", 8'h0, 8'h1);
  endtask

  function automatic logic [7:0] dist_model(logic [7:0] a, logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    if (d == 8'h0 || !d[7]) return d;
    return b - a;
  endfunction

  function automatic logic [7:0] test_model(logic [7:0] x);
    logic [7:0] y;
    y = x - 8'h01;
    return (y != 8'h0 && !y[7]) ? y : 8'h00;
  endfunction

  task automatic t_reset_state();
    in_valid0 = 1'b0; in_valid1 = 1'b0;
    apply_reset();
    chk("R9 acc0 in reset", acc0, 8'h00);
    chk("R9 halted0 in reset", {7'b0, halted0}, 8'h00);
    chk("R9 acc1 in reset", acc1, 8'h00);
    chk("R9 halted1 in reset", {7'b0, halted1}, 8'h00);
  endtask

  // R10 with R2 R3 R5 R6: default program
  task automatic t_default(logic [7:0] a, logic [7:0] b);
    apply_reset();
    in_valid1 = 1'b0;
    in_data0 = a; in_valid0 = 1'b1;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    in_data0 = b;
    wait_halt(0);
    chk($sformatf("R10 R3 R5 R6 dist(%0d,%0d)", a, b), acc0, dist_model(a, b));
    chk("R8 halted0 raised", {7'b0, halted0}, 8'h01);
    in_valid0 = 1'b0;
  endtask

  // R4 stall, then R1 R2 R6 R7 via test image
  task automatic t_test_image(logic [7:0] x, output logic [7:0] res);
    apply_reset();
    in_valid0 = 1'b0; in_valid1 = 1'b0;
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    chk("R4 acc held while strobe low", acc1, 8'h00);
    chk("R4 no progress while strobe low", {7'b0, halted1}, 8'h00);
    in_data1 = x; in_valid1 = 1'b1;
    wait_halt(1);
    res = acc1;
    chk($sformatf("R1 R2 R6 R7 test image x=%0h", x), acc1, test_model(x));
    in_valid1 = 1'b0;
  endtask

  task automatic t_freeze();
    logic [7:0] r;
    t_test_image(8'h33, r);
    for (int i = 0; i < 10; i++) begin
      in_data1 = 8'(i * 37 + 5); in_valid1 = i[0];
      @(negedge clk);
    end
    chk("R8 acc frozen after halt", acc1, test_model(8'h33));
    chk("R8 halted stays high", {7'b0, halted1}, 8'h01);
    in_valid1 = 1'b0;
  endtask

  task automatic t_reload();
    logic [7:0] r1, r2;
    t_test_image(8'h05, r1);
    t_test_image(8'h05, r2);
    chk("R9 data cell reloaded on reset", r2, 8'h04);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    t_reset_state();
    t_default(8'd9, 8'd5);
    t_default(8'd5, 8'd9);
    t_default(8'd7, 8'd7);
    t_default(8'd200, 8'd10);
    t_default(8'd0, 8'd0);
    t_test_image(8'h40, r);
    t_test_image(8'h80, r);
    t_test_image(8'h81, r);
    t_test_image(8'h01, r);
    t_test_image(8'h00, r);
    t_freeze();
    t_reload();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule